// File: doc/BRIEF.md
# Low-Power Sleep and Wake Controller

This block is the power-state portion of a microcontroller's system control space. It provides two word registers on a simple synchronous bus. The first register is a reset-control word. Writes to it are guarded by a 16-bit key, and a keyed write can raise a system reset request. The second register holds the low-power configuration: whether the core uses normal or deep sleep, whether it goes back to sleep when a handler returns, and whether interrupts that are not enabled may also wake it.

Around these registers sits a sleep and wake state machine. The core reports wait-for-interrupt and wait-for-event instructions, send-event instructions, external events, newly pending interrupts and handler-to-thread returns. The block decides when the core is asleep and drives one of two sleep outputs while it is. It produces a single-cycle wake pulse when the core must resume. A one-bit event latch remembers an event that arrives while the core is not waiting for one, so that the next wait-for-event completes at once.

Top module: `lp_sysctl`

## Requirements
- R1: After reset, core_sleep, core_deep_sleep, core_wake and sys_reset_req are 0, and both registers read as all zeros.
- R2: The reset-control word (bus_addr 0) always reads as zero. This covers the key field in bits 31:16, the little-endian flag in bit 15, the reset-request bit 2 and the reserved bit 1.
- R3: A write to bus_addr 0 whose bits 31:16 equal 0x05FA and whose bit 2 is 1 raises sys_reset_req for exactly one cycle, in the cycle after the write.
- R4: A write to bus_addr 0 with any other value in bits 31:16 is discarded: sys_reset_req stays 0 even when bit 2 is 1.
- R5: The low-power word (bus_addr 1) stores bit 1 (sleep-on-exit), bit 2 (deep sleep) and bit 4 (wide wake). All of its other bits read as 0. Addresses 2 and 3 read as 0 and ignore writes.
- R6: One cycle after cpu_wfi, the core is asleep. core_sleep is 1 when bit 2 of the low-power word is 0, and core_deep_sleep is 1 when it is 1. Only one of them is ever high.
- R7: While asleep, an interrupt that becomes pending and is enabled (irq_pend_new and irq_pend_enabled) gives core_wake = 1 in the next cycle. Both sleep outputs are 0 in that same cycle, and core_wake is 0 again one cycle later.
- R8: With bit 4 of the low-power word at 0, a pending interrupt that is not enabled does not wake the core. With bit 4 at 1, it does.
- R9: After cpu_wfe with no stored event, the core sleeps. An ext_event pulse, a cpu_sev pulse or an enabled pending interrupt wakes it.
- R10: An event (ext_event or cpu_sev) seen while the core is running is stored. The next cpu_wfe then produces a wake pulse without any sleep cycle and clears the store, so the following cpu_wfe sleeps.
- R11: exc_return_thread enters the selected low-power mode when bit 1 of the low-power word is 1, and has no effect when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Word address: 0 reset control, 1 low-power config |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed word (combinational) |
| cpu_wfi | input | 1 | Core executes wait-for-interrupt |
| cpu_wfe | input | 1 | Core executes wait-for-event |
| cpu_sev | input | 1 | Core executes send-event |
| ext_event | input | 1 | Event from outside the core |
| irq_pend_new | input | 1 | An interrupt enters the pending state this cycle |
| irq_pend_enabled | input | 1 | That newly pending interrupt is enabled |
| exc_return_thread | input | 1 | A handler returns to thread mode |
| core_sleep | output | 1 | Core in normal sleep |
| core_deep_sleep | output | 1 | Core in deep sleep |
| core_wake | output | 1 | One-cycle wake pulse |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The wake logic is driven with four kinds of entry: wait-for-interrupt, wait-for-event with the store empty, wait-for-event with the store full, and handler return with sleep-on-exit set and clear. Each entry is paired with the wake causes that should and should not end it. A disabled pending interrupt is tried under both wide-wake settings, which separates the narrow wake set from the wide one. An event sent while running, followed by two wait-for-event instructions, shows whether the store is set, consumed and cleared. Keyed and unkeyed reset-control writes with bit 2 set show whether the key comparison gates the request.

// File: rtl/lp_sysctl_pkg.sv
// Shared constants and types for the low-power system control block.
// Assumes a word-addressed register bus of at least 32 bits.
package lp_sysctl_pkg;

    // Key that unlocks the reset-control word (upper 16 bits of a write).
    localparam logic [15:0] RC_UNLOCK_KEY = 16'h05FA;
    localparam int unsigned KEY_W         = 16;

    // Bit positions the core-facing logic relies on.
    localparam int unsigned RC_REQ_BIT   = 2;
    localparam int unsigned LP_EXIT_BIT  = 1;
    localparam int unsigned LP_DEEP_BIT  = 2;
    localparam int unsigned LP_WIDE_BIT  = 4;

    // Word addresses of the two live registers.
    localparam int unsigned RC_INDEX = 0;
    localparam int unsigned LP_INDEX = 1;

    // Power state of the core as tracked by this block.
    typedef enum logic [1:0] {
        PS_RUN      = 2'd0,
        PS_WAIT_IRQ = 2'd1,
        PS_WAIT_EVT = 2'd2
    } pstate_e;

    // Stored low-power configuration.
    typedef struct packed {
        logic wide_wake;
        logic deep;
        logic exit_sleep;
    } lp_cfg_t;

endpackage

// File: rtl/lp_sysctl_regs.sv
// Register bank: keyed reset-control word and low-power config word.
// Assumes DATA_W >= 32 and single-cycle writes; reads are combinational.
module lp_sysctl_regs
    import lp_sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output lp_cfg_t           cfg,
    output logic              rst_pulse
);
    localparam int unsigned NUM_WORDS = 1 << ADDR_W;
    localparam int unsigned KEY_LSB   = DATA_W - KEY_W;

    logic              rc_sel;
    logic              lp_sel;
    logic              key_ok;
    logic [DATA_W-1:0] lp_word;
    logic [DATA_W-1:0] word_view [NUM_WORDS];

    assign rc_sel = (addr == ADDR_W'(RC_INDEX));
    assign lp_sel = (addr == ADDR_W'(LP_INDEX));
    assign key_ok = (wdata[DATA_W-1:KEY_LSB] == RC_UNLOCK_KEY);

    // Captures the three config bits on a write to the low-power word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we && lp_sel) begin
            cfg.wide_wake  <= wdata[LP_WIDE_BIT];
            cfg.deep       <= wdata[LP_DEEP_BIT];
            cfg.exit_sleep <= wdata[LP_EXIT_BIT];
        end
    end

    // Raises a one-cycle reset request for a keyed write with the request bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= we && rc_sel && key_ok && wdata[RC_REQ_BIT];
        end
    end

    // Assembles the readable image of the low-power word.
    always_comb begin
        lp_word              = '0;
        lp_word[LP_WIDE_BIT] = cfg.wide_wake;
        lp_word[LP_DEEP_BIT] = cfg.deep;
        lp_word[LP_EXIT_BIT] = cfg.exit_sleep;
    end

    // Per-address read images; the reset-control word and unused slots read zero.
    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_view
        if (g == LP_INDEX) begin : g_lp
            assign word_view[g] = lp_word;
        end else begin : g_zero
            assign word_view[g] = '0;
        end
    end

    assign rdata = word_view[addr];

    logic unused_wdata;
    assign unused_wdata = ^{wdata[KEY_LSB-1:LP_WIDE_BIT+1], wdata[3], wdata[0]};

endmodule

// File: rtl/lp_sysctl_wake_src.sv
// Classifies the core's inputs into wake causes for the power FSM.
// Assumes all inputs are single-cycle pulses synchronous to the clock.
module lp_sysctl_wake_src
    import lp_sysctl_pkg::*;
(
    input  lp_cfg_t cfg,
    input  logic    cpu_sev,
    input  logic    ext_event,
    input  logic    irq_pend_new,
    input  logic    irq_pend_enabled,
    output logic    evt,
    output logic    irq_wake
);
    logic irq_counts;

    // A pending interrupt counts if it is enabled or the wide wake set is on.
    assign irq_counts = irq_pend_new && (irq_pend_enabled || cfg.wide_wake);

    // Event for the latch or a waiting core: send-event, external, or wide-set pend.
    assign evt = cpu_sev || ext_event || (irq_pend_new && cfg.wide_wake);

    // Interrupt-class wake, valid for both wait states.
    assign irq_wake = irq_counts;

endmodule

// File: rtl/lp_sysctl_power_fsm.sv
// Sleep/wake state machine with a one-bit event latch.
// Assumes wfi/wfe/exit inputs only arrive while the core is running.
module lp_sysctl_power_fsm
    import lp_sysctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  lp_cfg_t cfg,
    input  logic    cpu_wfi,
    input  logic    cpu_wfe,
    input  logic    exc_return_thread,
    input  logic    evt,
    input  logic    irq_wake,
    output logic    core_sleep,
    output logic    core_deep_sleep,
    output logic    core_wake
);
    pstate_e st_q, st_d;
    logic    latch_q, latch_d;
    logic    wake_d, wake_q;
    logic    low_power;

    // Next state, latch update and wake decision.
    always_comb begin
        st_d    = st_q;
        latch_d = latch_q;
        wake_d  = 1'b0;
        unique case (st_q)
            PS_RUN: begin
                if (cpu_wfe) begin
                    if (latch_q || evt) begin
                        wake_d  = 1'b1;
                        latch_d = 1'b0;
                    end else begin
                        st_d = PS_WAIT_EVT;
                    end
                end else begin
                    if (cpu_wfi || (exc_return_thread && cfg.exit_sleep)) begin
                        st_d = PS_WAIT_IRQ;
                    end
                    if (evt) begin
                        latch_d = 1'b1;
                    end
                end
            end
            PS_WAIT_IRQ: begin
                if (irq_wake) begin
                    st_d   = PS_RUN;
                    wake_d = 1'b1;
                end else if (evt) begin
                    latch_d = 1'b1;
                end
            end
            PS_WAIT_EVT: begin
                if (irq_wake || evt) begin
                    st_d   = PS_RUN;
                    wake_d = 1'b1;
                end
            end
            default: begin
                st_d = PS_RUN;
            end
        endcase
    end

    // Holds power state, event latch and the registered wake pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= PS_RUN;
            latch_q <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            latch_q <= latch_d;
            wake_q  <= wake_d;
        end
    end

    // Routes the low-power indication to the sleep flavour currently selected.
    assign low_power       = (st_q != PS_RUN);
    assign core_sleep      = low_power && !cfg.deep;
    assign core_deep_sleep = low_power && cfg.deep;
    assign core_wake       = wake_q;

endmodule

// File: rtl/lp_sysctl.sv
// Top level: register bank, wake-cause decode and power FSM.
// Assumes a single clock domain and synchronous active-low reset.
module lp_sysctl
    import lp_sysctl_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cpu_wfi,
    input  logic              cpu_wfe,
    input  logic              cpu_sev,
    input  logic              ext_event,
    input  logic              irq_pend_new,
    input  logic              irq_pend_enabled,
    input  logic              exc_return_thread,
    output logic              core_sleep,
    output logic              core_deep_sleep,
    output logic              core_wake,
    output logic              sys_reset_req
);
    lp_cfg_t cfg;
    logic    evt;
    logic    irq_wake;

    lp_sysctl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .we        (bus_we),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .cfg       (cfg),
        .rst_pulse (sys_reset_req)
    );

    lp_sysctl_wake_src u_src (
        .cfg              (cfg),
        .cpu_sev          (cpu_sev),
        .ext_event        (ext_event),
        .irq_pend_new     (irq_pend_new),
        .irq_pend_enabled (irq_pend_enabled),
        .evt              (evt),
        .irq_wake         (irq_wake)
    );

    lp_sysctl_power_fsm u_fsm (
        .clk               (clk),
        .rst_n             (rst_n),
        .cfg               (cfg),
        .cpu_wfi           (cpu_wfi),
        .cpu_wfe           (cpu_wfe),
        .exc_return_thread (exc_return_thread),
        .evt               (evt),
        .irq_wake          (irq_wake),
        .core_sleep        (core_sleep),
        .core_deep_sleep   (core_deep_sleep),
        .core_wake         (core_wake)
    );

endmodule

// File: rtl/lp_sysctl_chk.sv
// Protocol checker for lp_sysctl, attached by bind.
module lp_sysctl_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cpu_wfi,
    input logic              cpu_wfe,
    input logic              exc_return_thread,
    input logic              core_sleep,
    input logic              core_deep_sleep,
    input logic              core_wake,
    input logic              sys_reset_req
);
    // R2
    rc_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(0)) |-> (bus_rdata == '0));

    // R5
    lp_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(1)) |-> ((bus_rdata & ~DATA_W'(32'h16)) == '0));

    // R3
    rst_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    // R4
    rst_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_we && bus_addr == ADDR_W'(0)
                                && bus_wdata[DATA_W-1:DATA_W-16] == 16'h05FA
                                && bus_wdata[2]));

    // R6
    sleep_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_sleep && core_deep_sleep));

    // R7
    wake_not_asleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wake |-> (!core_sleep && !core_deep_sleep));

    // R10
    wake_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_wake |-> $past(core_sleep || core_deep_sleep || cpu_wfe));

    // R11
    sleep_entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_sleep || core_deep_sleep)
            |-> $past(cpu_wfi || cpu_wfe || exc_return_thread || bus_we));

endmodule

bind lp_sysctl lp_sysctl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_addr          (bus_addr),
    .bus_we            (bus_we),
    .bus_wdata         (bus_wdata),
    .bus_rdata         (bus_rdata),
    .cpu_wfi           (cpu_wfi),
    .cpu_wfe           (cpu_wfe),
    .exc_return_thread (exc_return_thread),
    .core_sleep        (core_sleep),
    .core_deep_sleep   (core_deep_sleep),
    .core_wake         (core_wake),
    .sys_reset_req     (sys_reset_req)
);

// File: tb/test_lp_sysctl.sv
`timescale 1ns/100ps
module test_lp_sysctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_wfi = 0, cpu_wfe = 0, cpu_sev = 0, ext_event = 0;
    logic        irq_pend_new = 0, irq_pend_enabled = 0, exc_return_thread = 0;
    logic        core_sleep, core_deep_sleep, core_wake, sys_reset_req;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    lp_sysctl i_lp_sysctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_wfi(cpu_wfi),
        .cpu_wfe(cpu_wfe), .cpu_sev(cpu_sev), .ext_event(ext_event),
        .irq_pend_new(irq_pend_new), .irq_pend_enabled(irq_pend_enabled),
        .exc_return_thread(exc_return_thread), .core_sleep(core_sleep),
        .core_deep_sleep(core_deep_sleep), .core_wake(core_wake),
        .sys_reset_req(sys_reset_req)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Outputs packed as {sleep, deep, wake}.
    function automatic logic [2:0] pw();
        return {core_sleep, core_deep_sleep, core_wake};
    endfunction

    // One input cycle; returns at the following negedge with outputs updated.
    task automatic step(input bit wfi, wfe, sev, ev, pn, pe, er);
        @(negedge clk);
        cpu_wfi = wfi; cpu_wfe = wfe; cpu_sev = sev; ext_event = ev;
        irq_pend_new = pn; irq_pend_enabled = pe; exc_return_thread = er;
        @(negedge clk);
        cpu_wfi = 0; cpu_wfe = 0; cpu_sev = 0; ext_event = 0;
        irq_pend_new = 0; irq_pend_enabled = 0; exc_return_thread = 0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic req);
        @(negedge clk);
        bus_addr = a; bus_we = 1; bus_wdata = d;
        @(negedge clk);
        bus_we = 0;
        req = sys_reset_req;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "outputs", {28'd0, pw(), sys_reset_req}, 32'd0);
        rd(0, d); chk("R1", "rc word", d, 0);
        rd(1, d); chk("R1", "lp word", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        logic r;
        wr(1, 32'hFFFF_FFFF, r);
        rd(1, d); chk("R5", "lp stores bits 1,2,4", d, 32'h16);
        wr(0, 32'hFFFF_FFFF, r);
        rd(0, d); chk("R2", "rc reads zero", d, 0);
        wr(2, 32'hFFFF_FFFF, r);
        rd(2, d); chk("R5", "addr2 zero", d, 0);
        wr(1, 32'h0, r);
        rd(1, d); chk("R5", "lp cleared", d, 0);
    endtask

    task automatic t_key();
        logic r;
        wr(0, 32'h1234_0004, r); chk("R4", "bad key no req", r, 0);
        wr(0, 32'h05FB_0004, r); chk("R4", "near key no req", r, 0);
        wr(0, 32'h05FA_0000, r); chk("R3", "key without bit2", r, 0);
        wr(0, 32'h05FA_0004, r); chk("R3", "keyed req", r, 1);
        @(negedge clk);          chk("R3", "req one cycle", sys_reset_req, 0);
    endtask

    task automatic t_wfi();
        logic r;
        wr(1, 32'h0, r);
        step(1,0,0,0,0,0,0); chk("R6", "wfi normal sleep", pw(), 3'b100);
        step(0,0,0,0,0,0,0); chk("R6", "stays asleep", pw(), 3'b100);
        step(0,0,0,0,1,1,0); chk("R7", "enabled irq wakes", pw(), 3'b001);
        step(0,0,0,0,0,0,0); chk("R7", "wake one cycle", pw(), 3'b000);
        wr(1, 32'h4, r);
        step(1,0,0,0,0,0,0); chk("R6", "wfi deep sleep", pw(), 3'b010);
        step(0,0,0,0,1,1,0); chk("R7", "deep wake", pw(), 3'b001);
    endtask

    task automatic t_wide();
        logic r;
        wr(1, 32'h0, r);
        step(1,0,0,0,0,0,0);
        step(0,0,0,0,1,0,0); chk("R8", "disabled irq no wake", pw(), 3'b100);
        wr(1, 32'h10, r);    chk("R8", "still asleep", pw(), 3'b100);
        step(0,0,0,0,1,0,0); chk("R8", "wide set wakes", pw(), 3'b001);
        wr(1, 32'h0, r);
        step(0,1,0,0,0,0,0); chk("R8", "no stale event after wide wake", pw(), 3'b100);
        step(0,0,1,0,0,0,0);
    endtask

    task automatic t_wfe();
        step(0,1,0,0,0,0,0); chk("R9", "wfe sleeps", pw(), 3'b100);
        step(0,0,0,1,0,0,0); chk("R9", "ext event wakes", pw(), 3'b001);
        step(0,1,0,0,0,0,0);
        step(0,0,1,0,0,0,0); chk("R9", "sev wakes", pw(), 3'b001);
        step(0,1,0,0,0,0,0);
        step(0,0,0,0,1,1,0); chk("R9", "irq wakes wfe", pw(), 3'b001);
    endtask

    task automatic t_latch();
        step(0,0,1,0,0,0,0); chk("R10", "sev while running", pw(), 3'b000);
        step(0,1,0,0,0,0,0); chk("R10", "wfe completes at once", pw(), 3'b001);
        step(0,1,0,0,0,0,0); chk("R10", "latch cleared, sleeps", pw(), 3'b100);
        step(0,0,0,1,0,0,0); chk("R10", "wakes", pw(), 3'b001);
        step(0,0,0,1,0,0,0);
        step(0,1,0,0,0,0,0); chk("R10", "ext event latched", pw(), 3'b001);
    endtask

    task automatic t_exit();
        logic r;
        wr(1, 32'h0, r);
        step(0,0,0,0,0,0,1); chk("R11", "exit ignored when off", pw(), 3'b000);
        wr(1, 32'h2, r);
        step(0,0,0,0,0,0,1); chk("R11", "exit sleeps", pw(), 3'b100);
        step(0,0,0,0,1,1,0); chk("R11", "exit sleep wakes", pw(), 3'b001);
        wr(1, 32'h6, r);
        step(0,0,0,0,0,0,1); chk("R11", "exit deep", pw(), 3'b010);
        step(0,0,0,0,1,1,0);
        wr(1, 32'h0, r);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_key();
        t_wfi();
        t_wide();
        t_wfe();
        t_latch();
        t_exit();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule